// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller with Word Forwarding

This block sits between a processor load/store port and a slower main memory. It holds 4 KB of data as 256 lines of four 32-bit words, with a tag, a valid bit and a dirty bit beside every line. Each request address is split into a tag, a line index and a word index. The line named by the index is looked up. A matching valid line answers in one cycle. Any other case starts a line fill from memory.

During a fill, memory delivers the four words of the line in order, starting at word 0. The word the core asked for is returned as soon as it arrives, while the remaining words are still being written. A write that hits changes only the byte lanes it enables and marks the line dirty. A write that misses first fills the line and then merges its bytes into the arriving word. When a miss displaces a dirty line, the displaced line is copied into a holding register and offered to a write buffer. This offer runs alongside the fill request. Only one miss is in flight at a time.

Top module: `stream_dm_cache`

## Requirements
- R1: After reset every line is invalid and clean. `req_ready` is high, and `rsp_valid`, `mem_req_valid` and `wb_push_valid` are low. The first access to any line is therefore a miss.
- R2: Address bits 31:12 are the tag, bits 11:4 the line index and bits 3:2 the word within the line. A fill request carries the address {tag, index, 4'b0000}.
- R3: A request accepted when the indexed line is valid and its tag equals the address tag is a hit. `rsp_valid` is high in the cycle after acceptance, and no memory request is made.
- R4: A miss issues exactly one memory request. All four returned words are written into the line, and later reads of any word of that line hit and return the memory value.
- R5: During a fill, `rsp_valid` rises in the cycle after the requested word arrives, with that word. This happens before the fill ends whenever the word is not the last one in the line. Cycles with `mem_rvalid` low pause the fill.
- R6: A miss on a valid line holding a different tag replaces that line. A later access with the old tag misses.
- R7: A dirty displaced line is offered on the write-buffer port with address {old tag, index, 4'b0000}. Word 0 is in bits 31:0 and word 3 in bits 127:96. A clean displaced line is not offered. The offer is held stable until `wb_push_ready`.
- R8: A write hit updates byte lane i (bits 8i+7:8i) only where `req_be[i]` is set. It marks the line dirty and returns the merged word.
- R9: A write miss fills the line and merges the write bytes into the requested word as it arrives. It returns the merged word and leaves the line dirty.
- R10: Only one miss is outstanding. `req_ready` stays low from a miss until the last fill word is written and any victim offer is accepted. The memory request is held stable until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte-lane enables |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_rdata | output | 32 | Loaded word, or merged word for a store |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_ready | input | 1 | Memory accepts the fill request |
| mem_req_addr | output | 32 | Line-aligned fill address |
| mem_rvalid | input | 1 | Fill word valid |
| mem_rdata | input | 32 | Fill word |
| wb_push_valid | output | 1 | Dirty victim line offered |
| wb_push_ready | input | 1 | Write buffer takes the victim |
| wb_push_addr | output | 32 | Line-aligned victim address |
| wb_push_line | output | 128 | Victim line contents |

## Verification
Two events can fall in the same cycle: the victim hand-off to the write buffer and the acceptance of the fill request. Both come from a single conflict miss on a dirty line. The bench provokes this overlap by running the memory and write-buffer responders with zero delay. It then confirms that both handshakes completed on one edge, that the offered line equals the model's dirty data, and that the refilled line matches memory. Word forwarding also overlaps the fill that is still running. This is judged by counting the fill words seen when the response appears and by checking that `req_ready` is still low at that point, under both paused and unpaused fills.

// File: rtl/scache_pkg.sv
package scache_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int SETS       = 256;
    localparam int LINE_WORDS = 4;

    localparam int LANES  = DATA_W / 8;
    localparam int BOFF_W = $clog2(LANES);
    localparam int WIDX_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = BOFF_W + WIDX_W;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int LINE_W = LINE_WORDS * DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FILL
    } st_e;

    typedef struct packed {
        st_e                st;
        logic [TAG_W-1:0]   tag;
        logic [SET_W-1:0]   set;
        logic [WIDX_W-1:0]  widx;
        logic               wr;
        logic [DATA_W-1:0]  wdata;
        logic [LANES-1:0]   be;
        logic [WIDX_W-1:0]  fcnt;
        logic               wb_pend;
        logic [ADDR_W-1:0]  vic_addr;
        logic [LINE_W-1:0]  vic_line;
        logic               rsp_v;
        logic [DATA_W-1:0]  rsp_d;
    } ctl_t;
endpackage

// File: rtl/scache_lane_merge.sv
module scache_lane_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   old_word,
    input  logic [DATA_W-1:0]   new_word,
    input  logic [DATA_W/8-1:0] lane_en,
    output logic [DATA_W-1:0]   merged
);
    localparam int LANES = DATA_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = lane_en[i] ? new_word[8*i +: 8] : old_word[8*i +: 8];
    end
endmodule

// File: rtl/scache_store.sv
module scache_store #(
    parameter int SETS   = 256,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(SETS)-1:0]   rd_set,
    output logic [TAG_W-1:0]          rd_tag,
    output logic                      rd_valid,
    output logic                      rd_dirty,
    output logic [WORDS*DATA_W-1:0]   rd_line,
    input  logic                      wr_en,
    input  logic [$clog2(SETS)-1:0]   wr_set,
    input  logic [$clog2(WORDS)-1:0]  wr_word,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      meta_we,
    input  logic [$clog2(SETS)-1:0]   meta_set,
    input  logic [TAG_W-1:0]          meta_tag,
    input  logic                      meta_dirty
);
    localparam int SET_W  = $clog2(SETS);
    localparam int WIDX_W = $clog2(WORDS);

    logic [DATA_W-1:0] data_q [SETS*WORDS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [SETS-1:0]   valid_d, valid_q;
    logic [SETS-1:0]   dirty_d, dirty_q;

    always_ff @(posedge clk) begin
        if (wr_en) data_q[{wr_set, wr_word}] <= wr_data;
        if (meta_we) tag_q[meta_set] <= meta_tag;
    end

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (meta_we) begin
            valid_d[meta_set] = 1'b1;
            dirty_d[meta_set] = meta_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    assign rd_tag   = tag_q[rd_set];
    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign rd_line[w*DATA_W +: DATA_W] = data_q[{rd_set, WIDX_W'(w)}];
    end

    // A completed line install leaves the line valid
    assert_install_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meta_we |=> valid_q[$past(meta_set)]);

    // The dirty bit follows the install or write-hit request
    assert_dirty_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
        meta_we |=> dirty_q[$past(meta_set)] == $past(meta_dirty));

    logic [SET_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/stream_dm_cache.sv
module stream_dm_cache
    import scache_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [31:0]         req_addr,
    input  logic [31:0]         req_wdata,
    input  logic [3:0]          req_be,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [31:0]         mem_req_addr,
    input  logic                mem_rvalid,
    input  logic [31:0]         mem_rdata,
    output logic                wb_push_valid,
    input  logic                wb_push_ready,
    output logic [31:0]         wb_push_addr,
    output logic [127:0]        wb_push_line
);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(LINE_WORDS - 1);

    ctl_t d, q;
    st_e  st_q;

    // address fields of the incoming request
    logic [TAG_W-1:0]  a_tag;
    logic [SET_W-1:0]  a_set;
    logic [WIDX_W-1:0] a_widx;
    logic [1:0]        unused_boff;
    assign a_tag       = req_addr[ADDR_W-1 -: TAG_W];
    assign a_set       = req_addr[OFF_W +: SET_W];
    assign a_widx      = req_addr[BOFF_W +: WIDX_W];
    assign unused_boff = req_addr[BOFF_W-1:0];

    // store interface
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid, rd_dirty;
    logic [LINE_W-1:0] rd_line;
    logic              wr_en;
    logic [SET_W-1:0]  wr_set;
    logic [WIDX_W-1:0] wr_word;
    logic [DATA_W-1:0] wr_data;
    logic              meta_we;
    logic [SET_W-1:0]  meta_set;
    logic [TAG_W-1:0]  meta_tag;
    logic              meta_dirty;

    scache_store #(
        .SETS   (SETS),
        .WORDS  (LINE_WORDS),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (a_set),
        .rd_tag     (rd_tag),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .rd_line    (rd_line),
        .wr_en      (wr_en),
        .wr_set     (wr_set),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .meta_we    (meta_we),
        .meta_set   (meta_set),
        .meta_tag   (meta_tag),
        .meta_dirty (meta_dirty)
    );

    logic              hit;
    logic [DATA_W-1:0] hit_word;
    assign hit      = rd_valid && (rd_tag == a_tag);
    assign hit_word = rd_line[a_widx*DATA_W +: DATA_W];

    // byte-lane merge: old word is the stored word on a hit, the fill word during a fill
    logic              in_fill;
    logic [DATA_W-1:0] m_old, m_new, m_out;
    logic [LANES-1:0]  m_be;
    assign in_fill = (q.st == ST_FILL);
    assign m_old   = in_fill ? mem_rdata : hit_word;
    assign m_new   = in_fill ? q.wdata   : req_wdata;
    assign m_be    = in_fill ? q.be      : req_be;

    scache_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word (m_old),
        .new_word (m_new),
        .lane_en  (m_be),
        .merged   (m_out)
    );

    logic [DATA_W-1:0] fill_word;
    assign fill_word = (q.wr && q.fcnt == q.widx) ? m_out : mem_rdata;

    always_comb begin
        d             = q;
        d.rsp_v       = 1'b0;
        wr_en         = 1'b0;
        wr_set        = a_set;
        wr_word       = a_widx;
        wr_data       = m_out;
        meta_we       = 1'b0;
        meta_set      = a_set;
        meta_tag      = a_tag;
        meta_dirty    = 1'b1;
        mem_req_valid = 1'b0;
        req_ready     = (q.st == ST_IDLE) && !q.wb_pend;

        if (q.wb_pend && wb_push_ready) d.wb_pend = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    if (hit) begin
                        d.rsp_v = 1'b1;
                        if (req_write) begin
                            wr_en   = 1'b1;
                            meta_we = 1'b1;
                            d.rsp_d = m_out;
                        end else begin
                            d.rsp_d = hit_word;
                        end
                    end else begin
                        d.st    = ST_ISSUE;
                        d.tag   = a_tag;
                        d.set   = a_set;
                        d.widx  = a_widx;
                        d.wr    = req_write;
                        d.wdata = req_wdata;
                        d.be    = req_be;
                        if (rd_valid && rd_dirty) begin
                            d.wb_pend  = 1'b1;
                            d.vic_addr = {rd_tag, a_set, {OFF_W{1'b0}}};
                            d.vic_line = rd_line;
                        end
                    end
                end
            end
            ST_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    d.st   = ST_FILL;
                    d.fcnt = '0;
                end
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    wr_en   = 1'b1;
                    wr_set  = q.set;
                    wr_word = q.fcnt;
                    wr_data = fill_word;
                    if (q.fcnt == q.widx) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = fill_word;
                    end
                    d.fcnt = q.fcnt + 1'b1;
                    if (q.fcnt == LAST_W) begin
                        meta_we    = 1'b1;
                        meta_set   = q.set;
                        meta_tag   = q.tag;
                        meta_dirty = q.wr;
                        d.st       = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st_q          = q.st;
    assign rsp_valid     = q.rsp_v;
    assign rsp_rdata     = q.rsp_d;
    assign mem_req_addr  = {q.tag, q.set, {OFF_W{1'b0}}};
    assign wb_push_valid = q.wb_pend;
    assign wb_push_addr  = q.vic_addr;
    assign wb_push_line  = q.vic_line;

    // fill request is held until memory takes it
    assert_fill_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // a second request cannot be taken while a fill is being requested
    assert_single_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // victim offer is held until the write buffer takes it
    assert_victim_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_push_valid && !wb_push_ready |=> wb_push_valid && $stable(wb_push_addr)
                                            && $stable(wb_push_line));

    // a response during a fill follows an arriving fill word
    assert_stream_follows_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(st_q) == ST_FILL |-> $past(mem_rvalid));

    // a response out of idle follows an accepted request
    assert_hit_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(st_q) == ST_IDLE |-> $past(req_valid && req_ready));
endmodule

// File: tb/stream_dm_cache_bench.sv
`timescale 1ns/1ps
module stream_dm_cache_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_ready, req_write;
    logic [31:0]  req_addr, req_wdata;
    logic [3:0]   req_be;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         mem_req_valid, mem_req_ready;
    logic [31:0]  mem_req_addr;
    logic         mem_rvalid;
    logic [31:0]  mem_rdata;
    logic         wb_push_valid, wb_push_ready;
    logic [31:0]  wb_push_addr;
    logic [127:0] wb_push_line;

    always #2.5 clk = ~clk;

    stream_dm_cache u_stream_dm_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wb_push_valid(wb_push_valid), .wb_push_ready(wb_push_ready),
        .wb_push_addr(wb_push_addr), .wb_push_line(wb_push_line)
    );

    int tests = 0, fails = 0;
    bit finished = 0;
    int mem_delay = 0, wb_delay = 0;
    bit gap_en = 0;
    int mreq_cnt = 0, push_cnt = 0, both_cnt = 0, fill_seen = 0;
    logic [31:0]  last_mreq_addr, last_push_addr;
    logic [127:0] last_push_line;

    // reference model of cache contents
    bit          m_valid [256];
    bit          m_dirty [256];
    logic [19:0] m_tag   [256];
    logic [31:0] m_data  [256][4];

    function automatic logic [31:0] mw(logic [31:0] a);
        return (a * 32'h0001_0193) ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory responder
    initial begin
        mem_req_ready = 0; mem_rvalid = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [31:0] a;
                repeat (mem_delay) @(negedge clk);
                mem_req_ready = 1;
                a = mem_req_addr;
                last_mreq_addr = a;
                @(negedge clk);
                mem_req_ready = 0;
                for (int k = 0; k < 4; k++) begin
                    if (gap_en && k == 2) begin
                        mem_rvalid = 0;
                        @(negedge clk);
                    end
                    mem_rvalid = 1;
                    mem_rdata  = mw(a + 32'(4*k));
                    @(negedge clk);
                end
                mem_rvalid = 0;
            end
        end
    end

    // write-buffer responder
    initial begin
        wb_push_ready = 0;
        forever begin
            @(negedge clk);
            if (wb_push_valid) begin
                repeat (wb_delay) @(negedge clk);
                wb_push_ready  = 1;
                last_push_addr = wb_push_addr;
                last_push_line = wb_push_line;
                @(negedge clk);
                wb_push_ready = 0;
            end
        end
    end

    // handshake monitor
    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready) mreq_cnt++;
        if (wb_push_valid && wb_push_ready) push_cnt++;
        if (mem_req_valid && mem_req_ready && wb_push_valid && wb_push_ready) both_cnt++;
        if (mem_rvalid) fill_seen++;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // one access; called at a negedge
    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, output bit was_hit);
        logic [7:0]   s  = a[11:4];
        int           w  = int'(a[3:2]);
        logic [19:0]  tg = a[31:12];
        bit           exp_hit, exp_push;
        logic [31:0]  exp_paddr, exp_rsp;
        logic [127:0] exp_pline;
        int           mreq0, push0, lat;

        exp_hit   = m_valid[s] && m_tag[s] == tg;
        exp_push  = !exp_hit && m_valid[s] && m_dirty[s];
        exp_paddr = {m_tag[s], s, 4'h0};
        exp_pline = {m_data[s][3], m_data[s][2], m_data[s][1], m_data[s][0]};
        if (!exp_hit) begin
            for (int k = 0; k < 4; k++) m_data[s][k] = mw({tg, s, 4'h0} + 32'(4*k));
            m_valid[s] = 1; m_tag[s] = tg; m_dirty[s] = 0;
        end
        if (wr) begin
            m_data[s][w] = merge(m_data[s][w], wd, be);
            m_dirty[s] = 1;
        end
        exp_rsp = m_data[s][w];

        mreq0 = mreq_cnt; push0 = push_cnt;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        fill_seen = 0;
        lat = 1;
        while (!rsp_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        was_hit = (lat == 1);
        check(rsp_valid, "R5", 0, 1);
        if (wr) check(rsp_rdata == exp_rsp, exp_hit ? "R8" : "R9", rsp_rdata, exp_rsp);
        else    check(rsp_rdata == exp_rsp, exp_hit ? "R3" : "R4", rsp_rdata, exp_rsp);
        if (exp_hit) begin
            check(lat == 1, "R3", lat, 1);
        end else begin
            check(lat > 1, "R4", lat, 2);
            check(fill_seen == w + 1, "R5", fill_seen, w + 1);
            if (w < 3) check(!req_ready, "R10", req_ready, 0);
        end
        while (!req_ready) @(negedge clk);
        if (exp_hit) begin
            check(mreq_cnt == mreq0, "R3", mreq_cnt - mreq0, 0);
        end else begin
            check(mreq_cnt == mreq0 + 1, "R4", mreq_cnt - mreq0, 1);
            check(last_mreq_addr == {tg, s, 4'h0}, "R2", last_mreq_addr, {tg, s, 4'h0});
        end
        check(push_cnt == push0 + (exp_push ? 1 : 0), "R7", push_cnt - push0, exp_push);
        if (exp_push) begin
            check(last_push_addr == exp_paddr, "R7", last_push_addr, exp_paddr);
            check(last_push_line == exp_pline, "R7", last_push_line, exp_pline);
        end
    endtask

    initial begin
        bit h;
        for (int i = 0; i < 256; i++) begin m_valid[i] = 0; m_dirty[i] = 0; end
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state at the ports
        check(req_ready == 1, "R1", req_ready, 1);
        check(rsp_valid == 0, "R1", rsp_valid, 0);
        check(mem_req_valid == 0, "R1", mem_req_valid, 0);
        check(wb_push_valid == 0, "R1", wb_push_valid, 0);

        // R1/R4/R5: first touch of every line misses; requested word position sweeps
        for (int s = 0; s < 256; s++) begin
            gap_en = (s % 7 == 3);
            mem_delay = s % 3;
            access(0, {20'h0000A, 8'(s), 2'(s % 4), 2'b00}, 0, 0, h);
            check(!h, "R1", h, 0);
        end
        gap_en = 0; mem_delay = 0;

        // R3/R4: every word of every line now hits
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 4; w++) begin
                access(0, {20'h0000A, 8'(s), 2'(w), 2'b00}, 0, 0, h);
                check(h, "R4", h, 1);
            end

        // R8: write hits with every byte-enable pattern
        for (int s = 0; s < 64; s++) begin
            access(1, {20'h0000A, 8'(s), 2'(s % 4), 2'b00}, 32'hDEAD_0000 | s, 4'(s % 16), h);
            check(h, "R8", h, 1);
        end

        // R6/R7/R10: conflict misses over dirty and clean lines, victim and fill overlap
        for (int s = 0; s < 128; s++) begin
            mem_delay = (s % 6 == 1) ? 0 : s % 3;
            wb_delay  = (s % 2 == 1) ? 0 : 6;
            gap_en    = (s % 5 == 0);
            access(0, {20'h0000B, 8'(s), 2'((s + 1) % 4), 2'b00}, 0, 0, h);
            check(!h, "R6", h, 0);
        end
        check(both_cnt > 0, "R7", both_cnt, 1);
        mem_delay = 0; wb_delay = 0; gap_en = 0;

        // R6: the displaced tag no longer hits
        access(0, {20'h0000A, 8'd0, 2'd1, 2'b00}, 0, 0, h);
        check(!h, "R6", h, 0);
        access(0, {20'h0000A, 8'd70, 2'd2, 2'b00}, 0, 0, h);
        check(!h, "R6", h, 0);

        // R9: write misses allocate and merge, then read back and evict dirty lines
        for (int s = 200; s < 216; s++) begin
            access(1, {20'h0000C, 8'(s), 2'(s % 4), 2'b00}, 32'h1234_5678 ^ s, 4'(s % 16), h);
            check(!h, "R9", h, 0);
            access(0, {20'h0000C, 8'(s), 2'(s % 4), 2'b00}, 0, 0, h);
            check(h, "R9", h, 1);
        end
        for (int s = 200; s < 216; s++) begin
            wb_delay = s % 4;
            access(0, {20'h0000D, 8'(s), 2'(3 - s % 4), 2'b00}, 0, 0, h);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule